// File: doc/BRIEF.md
# Spin Lock Acquirer with Exponential Backoff

This block is a per-requester controller that takes a spin lock held in shared memory and later gives it back. On the local side it accepts an acquire command and a release command, and it reports ownership on a single `acquired` flag. On the memory side it drives a request port that issues three kinds of operation on the lock word: plain loads, atomic test-and-set operations and plain stores.

To acquire, the controller reads the lock word with ordinary loads for as long as it reads nonzero. This keeps atomic traffic off the memory system while another agent owns the lock. When a load returns zero, the controller issues exactly one test-and-set. A zero result means the lock is now owned. A nonzero result means another agent won the race. In that case the controller stays silent for a backoff delay and then resumes polling. The delay doubles with each consecutive failure up to a cap, so the requester is not idle long after the lock frees up. To release, the controller writes zero with a plain store. Only one memory request is outstanding at any time.

The memory, any caches and any fairness between requesters belong to the surrounding system.

Top module: `spin_lock_agent`

## Requirements
- R1: While a load of the lock word returns a nonzero value, the controller issues another load (`memReqOp` = 2'b00) and never a test-and-set. Every test-and-set is immediately preceded by a load response of zero.
- R2: Each load response of zero is followed by exactly one test-and-set request (`memReqOp` = 2'b01).
- R3: A test-and-set response of zero raises `acquired` on the next cycle. A nonzero response starts a backoff, after which the controller polls with loads again.
- R4: After the n-th consecutive failed test-and-set of one acquisition, no request is issued for exactly `K_DELAY << min(n-1, MAX_EXP)` cycles. The next load request first appears in the cycle after that delay ends, which is one cycle after the last backoff cycle.
- R5: The backoff exponent saturates at `MAX_EXP`, so every failure after the cap gives a delay of `K_DELAY << MAX_EXP`.
- R6: The backoff exponent returns to zero after each successful acquisition. The first failure of the next acquisition therefore waits `K_DELAY` cycles.
- R7: A release command while the lock is owned issues one store (`memReqOp` = 2'b10) that writes the free value 0. `acquired` stays high until that store is accepted and then drops in the following cycle.
- R8: A release command while the lock is not owned is ignored: no store is issued and `acquired` does not change. An acquire command while the controller is not idle is also ignored.
- R9: A request stays valid with an unchanged operation until `memReqReady` is high. Only one request is outstanding at a time. Loads and test-and-set operations wait for one response, and a store expects none.
- R10: After reset, `acquired` and `memReqValid` are low, the controller is idle and the backoff exponent is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqReq | input | 1 | Acquire command, taken when the controller is idle |
| relReq | input | 1 | Release command, taken while the lock is owned |
| acquired | output | 1 | High while this requester owns the lock |
| memReqValid | output | 1 | Memory request valid |
| memReqOp | output | 2 | Operation: 00 load, 01 test-and-set (writes 1), 10 store of 0 |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Response to the outstanding load or test-and-set |
| memRspData | input | DATA_W | Lock word value returned by the response |

## Verification
The bench goes after the race case: a load sees the lock free but the following test-and-set fails. A design that issued test-and-set while the lock looked held, or that skipped the backoff, would show extra atomic requests or a request gap that is too short. The bench sweeps up to five consecutive failures and checks every gap against the shifted delay. It looks past the saturation point, where a missing cap gives a gap that keeps doubling. It also checks the first failure after a successful acquire, where an exponent that was not cleared gives a gap that is too long. Stalls on the ready line during polling and during release check that a request is held and that ownership is not dropped before the store is accepted. Release and acquire commands given at the wrong moment must leave no store and no extra load on the port.

// File: rtl/spin_lock_pkg.sv
package spin_lock_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_TAS   = 2'b01,
    OP_STORE = 2'b10
  } memOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_REQ,
    ST_POLL_WAIT,
    ST_TAS_REQ,
    ST_TAS_WAIT,
    ST_BACKOFF,
    ST_HELD,
    ST_RELEASE
  } lockState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTimer;  // start a backoff with the current exponent
    logic bumpExp;    // a test-and-set failed
    logic clearExp;   // a test-and-set succeeded
    logic tick;       // one backoff cycle elapsed
  } dpStrobe_t;

endpackage

// File: rtl/spin_lock_dp.sv
module spin_lock_dp
  import spin_lock_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int K_DELAY = 4,
  parameter int MAX_EXP = 6,
  parameter int EXP_W   = $clog2(MAX_EXP + 2),
  parameter int TIMER_W = $clog2((K_DELAY << MAX_EXP) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rspData,
  output logic              lockFree,
  output logic              timerDone,
  output logic              timerBusy
);

  logic [EXP_W-1:0]   expCnt;
  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] delayNext;

  assign lockFree  = (rspData == '0);
  assign delayNext = TIMER_W'(K_DELAY) << expCnt;
  assign timerDone = (timer == TIMER_W'(1));
  assign timerBusy = (timer != '0);

  // backoff exponent, saturating at the cap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      expCnt <= '0;
    end else if (strobe.clearExp) begin
      expCnt <= '0;
    end else if (strobe.bumpExp && (expCnt != EXP_W'(MAX_EXP))) begin
      expCnt <= expCnt + EXP_W'(1);
    end
  end

  // delay timer, counts the backoff cycles down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadTimer) begin
      timer <= delayNext;
    end else if (strobe.tick && timerBusy) begin
      timer <= timer - TIMER_W'(1);
    end
  end

  AST_EXP_CAP: assert property (@(posedge clk) disable iff (!rstN)
    expCnt <= EXP_W'(MAX_EXP));  // R5

  AST_EXP_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearExp |=> (delayNext == TIMER_W'(K_DELAY)));  // R6

endmodule

// File: rtl/spin_lock_ctrl.sv
module spin_lock_ctrl
  import spin_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acqReq,
  input  logic       relReq,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       lockFree,
  input  logic       timerDone,
  output logic       memReqValid,
  output logic [1:0] memReqOp,
  output logic       acquired,
  output dpStrobe_t  strobe
);

  lockState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:      if (acqReq) stateNext = ST_POLL_REQ;
      ST_POLL_REQ:  if (memReqReady) stateNext = ST_POLL_WAIT;
      ST_POLL_WAIT: if (memRspValid) stateNext = lockFree ? ST_TAS_REQ : ST_POLL_REQ;
      ST_TAS_REQ:   if (memReqReady) stateNext = ST_TAS_WAIT;
      ST_TAS_WAIT:  if (memRspValid) stateNext = lockFree ? ST_HELD : ST_BACKOFF;
      ST_BACKOFF:   if (timerDone) stateNext = ST_POLL_REQ;
      ST_HELD:      if (relReq) stateNext = ST_RELEASE;
      ST_RELEASE:   if (memReqReady) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadTimer = (state == ST_TAS_WAIT) && memRspValid && !lockFree;
    strobe.bumpExp   = (state == ST_TAS_WAIT) && memRspValid && !lockFree;
    strobe.clearExp  = (state == ST_TAS_WAIT) && memRspValid && lockFree;
    strobe.tick      = (state == ST_BACKOFF);
  end

  always_comb begin
    memReqValid = 1'b0;
    memReqOp    = OP_LOAD;
    unique case (state)
      ST_POLL_REQ: memReqValid = 1'b1;
      ST_TAS_REQ:  begin memReqValid = 1'b1; memReqOp = OP_TAS;   end
      ST_RELEASE:  begin memReqValid = 1'b1; memReqOp = OP_STORE; end
      default:     ;
    endcase
  end

  assign acquired = (state == ST_HELD) || (state == ST_RELEASE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqOp)));  // R9

  AST_TAS_AFTER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReqValid) && (memReqOp == OP_TAS)) |-> $past(memRspValid && lockFree));  // R2

  AST_ACQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(acquired) |-> $past(memReqValid && memReqReady && (memReqOp == OP_STORE)));  // R7

  AST_ACQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acquired) |-> $past(memRspValid && lockFree));  // R3

endmodule

// File: rtl/spin_lock_agent.sv
module spin_lock_agent
  import spin_lock_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int K_DELAY = 4,
  parameter int MAX_EXP = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqReq,
  input  logic              relReq,
  output logic              acquired,
  output logic              memReqValid,
  output logic [1:0]        memReqOp,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);

  localparam int EXP_W   = $clog2(MAX_EXP + 2);
  localparam int TIMER_W = $clog2((K_DELAY << MAX_EXP) + 1);

  dpStrobe_t strobe;
  logic      lockFree;
  logic      timerDone;
  logic      timerBusy;

  spin_lock_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .acqReq      (acqReq),
    .relReq      (relReq),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .lockFree    (lockFree),
    .timerDone   (timerDone),
    .memReqValid (memReqValid),
    .memReqOp    (memReqOp),
    .acquired    (acquired),
    .strobe      (strobe)
  );

  spin_lock_dp #(
    .DATA_W  (DATA_W),
    .K_DELAY (K_DELAY),
    .MAX_EXP (MAX_EXP),
    .EXP_W   (EXP_W),
    .TIMER_W (TIMER_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rspData   (memRspData),
    .lockFree  (lockFree),
    .timerDone (timerDone),
    .timerBusy (timerBusy)
  );

  AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    timerBusy |-> !memReqValid);  // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (!acquired && !memReqValid));  // R10

endmodule

// File: tb/spin_lock_agent_tb.sv
module spin_lock_agent_tb;

  localparam int DATA_W  = 8;
  localparam int K_DELAY = 3;
  localparam int MAX_EXP = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              acqReq = 1'b0;
  logic              relReq = 1'b0;
  logic              acquired;
  logic              memReqValid;
  logic [1:0]        memReqOp;
  logic              memReqReady;
  logic              memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;
  logic              stallReady = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // memory model state
  int negCnt = 0;
  int lockVal = 0;
  int holdPolls = 0;
  int tasFails = 0;
  int loads = 0, tasOps = 0, stores = 0;
  int failRun = 0;
  int failNeg = 0;
  bit gapArmed = 0;
  bit lastLoadZero = 0;
  bit pendingRsp = 0;
  int pendData = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign memReqReady = ~stallReady;

  spin_lock_agent #(.DATA_W(DATA_W), .K_DELAY(K_DELAY), .MAX_EXP(MAX_EXP)) u_dut (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq), .acquired(acquired),
    .memReqValid(memReqValid), .memReqOp(memReqOp), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expectGap(input int n);
    int e;
    e = (n - 1 > MAX_EXP) ? MAX_EXP : n - 1;
    return (K_DELAY << e) + 1;
  endfunction

  // memory model: works on the falling edge, away from the DUT's edge
  always @(negedge clk) begin
    negCnt++;
    if (pendingRsp) begin
      memRspValid = 1'b1;
      memRspData  = DATA_W'(pendData);
      pendingRsp  = 0;
    end else begin
      memRspValid = 1'b0;
    end
    if (rstN && memReqValid && memReqReady) begin
      case (memReqOp)
        2'b00: begin
          if (gapArmed) begin
            check(negCnt - failNeg == expectGap(failRun),
                  (failRun == 1) ? "R6 first backoff gap" :
                  ((failRun - 1 > MAX_EXP) ? "R5 capped backoff gap" : "R4 backoff gap"),
                  negCnt - failNeg, expectGap(failRun));
            gapArmed = 0;
          end
          loads++;
          if (holdPolls > 0) begin pendData = 1; holdPolls--; end
          else pendData = lockVal;
          lastLoadZero = (pendData == 0);
          pendingRsp = 1;
        end
        2'b01: begin
          check(lastLoadZero, "R1 test-and-set after zero load", lastLoadZero, 1);
          lastLoadZero = 0;
          tasOps++;
          if (tasFails > 0) begin
            pendData = 1; tasFails--;
          end else begin
            pendData = lockVal; lockVal = 1;
          end
          if (pendData != 0) begin
            failRun++; failNeg = negCnt + 1; gapArmed = 1;
          end else begin
            failRun = 0;
          end
          pendingRsp = 1;
        end
        2'b10: begin
          stores++;
          lockVal = 0;
        end
        default: check(0, "R9 legal operation", memReqOp, 0);
      endcase
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseAcq();
    acqReq = 1'b1; step(1); acqReq = 1'b0;
  endtask

  task automatic pulseRel();
    relReq = 1'b1; step(1); relReq = 1'b0;
  endtask

  task automatic clearCounts();
    loads = 0; tasOps = 0; stores = 0;
  endtask

  task automatic waitAcq(input string tag);
    int n = 0;
    while (!acquired && n < 2000) begin step(1); n++; end
    check(acquired, tag, acquired, 1);
  endtask

  task automatic doRelease();
    pulseRel();
    step(3);
    check(!acquired && lockVal == 0, "R7 release store frees lock", lockVal, 0);
  endtask

  initial begin
    step(3);
    check(!acquired && !memReqValid, "R10 reset outputs", {acquired, memReqValid}, 0);
    rstN = 1'b1;
    step(2);
    check(!acquired && !memReqValid, "R10 idle after reset", {acquired, memReqValid}, 0);

    // free lock: one load, one test-and-set
    clearCounts();
    pulseAcq();
    waitAcq("R3 acquire of free lock");
    step(1);
    check(loads == 1 && tasOps == 1, "R2 single attempt on free lock", loads * 10 + tasOps, 11);

    // acquire while holding is ignored
    clearCounts();
    pulseAcq();
    step(5);
    check(acquired && loads == 0 && tasOps == 0, "R8 acquire while held ignored", loads + tasOps, 0);

    // release with the store stalled
    stallReady = 1'b1;
    pulseRel();
    step(3);
    check(acquired, "R7 acquired held until store accepted", acquired, 1);
    check(memReqValid && memReqOp == 2'b10, "R9 store held during stall", memReqOp, 2);
    stallReady = 1'b0;
    step(2);
    check(!acquired && stores == 1, "R7 acquired drops after store", stores, 1);

    // release while idle is ignored
    clearCounts();
    pulseRel();
    step(5);
    check(stores == 0 && !memReqValid && !acquired, "R8 release while idle ignored", stores, 0);

    // sweep the number of polls that see the lock held
    for (int h = 0; h <= 5; h++) begin
      clearCounts();
      holdPolls = h;
      pulseAcq();
      waitAcq("R1 acquire after held polls");
      step(1);
      check(loads == h + 1, "R1 poll count", loads, h + 1);
      check(tasOps == 1, "R1 no atomic while held", tasOps, 1);
      doRelease();
    end

    // sweep consecutive test-and-set failures (gaps checked in the model)
    for (int f = 1; f <= 5; f++) begin
      clearCounts();
      tasFails = f;
      pulseAcq();
      waitAcq("R3 acquire after failed attempts");
      step(1);
      check(tasOps == f + 1, "R3 attempts after failures", tasOps, f + 1);
      check(loads == f + 1, "R3 repoll after each failure", loads, f + 1);
      doRelease();
    end

    // release during polling is ignored
    clearCounts();
    holdPolls = 20;
    pulseAcq();
    step(6);
    pulseRel();
    waitAcq("R8 acquire completes after stray release");
    check(stores == 0, "R8 stray release made no store", stores, 0);
    doRelease();

    // load request held under a stall
    clearCounts();
    stallReady = 1'b1;
    holdPolls = 3;
    pulseAcq();
    step(4);
    check(memReqValid && memReqOp == 2'b00 && loads == 0, "R9 load held during stall", loads, 0);
    stallReady = 1'b0;
    waitAcq("R9 acquire after stall");
    step(1);
    check(loads == 4, "R9 loads after stall", loads, 4);
    doRelease();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule